// File: doc/BRIEF.md
# Multicycle Floating-Point Issue Interlock

This block sits beside the decode stage of an in-order pipeline. The pipeline has four execution paths: a single-cycle integer path, a pipelined FP adder, a pipelined FP multiplier and a non-pipelined FP divider. Each cycle the block looks at the instruction held in decode and decides whether it may issue. When it may not, the block raises a stall. The instruction then stays in decode, and nothing new enters execution that cycle.

The block records when every issued instruction will use the single write-back port. It uses a shift register of future write-back slots for this. For each architectural register it keeps a countdown of cycles until the pending write lands. A separate counter tracks how long the divider stays occupied.

From this state the block finds four hazards, each reported on its own flag:
- a divide issued while the divider is busy;
- two results claiming the same write-back cycle;
- a source register whose producer has not reached write-back;
- a destination that would be written before an older, slower write to the same register.

Operands are read in decode, so write-after-read cannot happen and is not checked.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no write is pending, no write-back slot is reserved and the divider is idle. The first instruction after reset therefore issues, whatever its sources and destination.
- R2: `stall` and every cause flag are low whenever `id_valid` is low. `issue_go` is high exactly when `id_valid` is high and `stall` is low.
- R3: Unit codes on `id_unit` are 0 integer, 1 FP add, 2 FP multiply and 3 FP divide. The added latencies are 0, 3, 6 and 24. An instruction issued in cycle t writes back in cycle t+L+1. An enabled source whose producer has not reached its write-back cycle raises `stall_raw`. The stall lasts until the producer's write-back cycle, when the result can be forwarded. This gives no stall after an integer producer, 3 stall cycles after an add and 6 after a multiply.
- R4: A register-writing instruction whose write-back cycle is already reserved by an earlier instruction raises `stall_wb`. An example is an integer write issued 3 cycles after an add.
- R5: An instruction with `id_dst_we` low reserves no write-back slot and leaves no pending write. It is never stalled for a write-back conflict or a write-after-write hazard.
- R6: A divide raises `stall_div` until 24 cycles have passed since the previous divide issued. While the divider is busy, instructions for the other units still issue.
- R7: A register-writing instruction raises `stall_waw` when an earlier write to the same register would land in the same cycle as its own write or later.
- R8: Back-to-back adds and multiplies with no dependences issue one per cycle. This allows 4 adds or 7 multiplies in flight.
- R9: Each cause flag reports only its own hazard. A write-back conflict with no dependence and no busy divider raises `stall_wb` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_unit | input | 2 | Execution path of that instruction (0 int, 1 add, 2 mul, 3 div) |
| id_dst | input | 5 | Destination register index |
| id_dst_we | input | 1 | Instruction writes its destination |
| id_src1 | input | 5 | First source register index |
| id_src1_en | input | 1 | First source is read |
| id_src2 | input | 5 | Second source register index |
| id_src2_en | input | 1 | Second source is read |
| issue_go | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode |
| stall_div | output | 1 | Divider busy |
| stall_wb | output | 1 | Write-back cycle already taken |
| stall_raw | output | 1 | Source not yet available |
| stall_waw | output | 1 | Older write to the destination not yet done |

## Verification
The assertions assume that the decode stage keeps a stalled instruction on the inputs. They also assume that a register index always names an existing register. The forwarding assertion further assumes that a dependent instruction follows its integer producer in the very next cycle.

The stimulus changes inputs only on the falling clock edge, and it repeats a stalled instruction unchanged until it issues. Between scenarios it leaves the pipeline idle for longer than the divider latency, so no scenario sees leftover reservations from another.

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock #(
  parameter int NREG    = 32,
  parameter int LAT_INT = 0,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 6,
  parameter int LAT_DIV = 24,
  localparam int RW   = $clog2(NREG),
  localparam int MAXL = (LAT_DIV > LAT_MUL) ?
                        ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD) :
                        ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD),
  localparam int CW   = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [1:0]    id_unit,
  input  logic [RW-1:0] id_dst,
  input  logic          id_dst_we,
  input  logic [RW-1:0] id_src1,
  input  logic          id_src1_en,
  input  logic [RW-1:0] id_src2,
  input  logic          id_src2_en,
  output logic          issue_go,
  output logic          stall,
  output logic          stall_div,
  output logic          stall_wb,
  output logic          stall_raw,
  output logic          stall_waw
);

  logic [CW-1:0] lat;
  logic [CW-1:0] cnt [NREG];
  logic [CW-1:0] div_cnt;
  logic [MAXL:1] res, res_n;
  logic          wb_hit;
  logic          wr;

  always_comb begin
    case (id_unit)
      2'd0:    lat = CW'(LAT_INT);
      2'd1:    lat = CW'(LAT_ADD);
      2'd2:    lat = CW'(LAT_MUL);
      default: lat = CW'(LAT_DIV);
    endcase
  end

  always_comb begin
    wb_hit = 1'b0;
    for (int k = 1; k <= MAXL; k++)
      if (int'(lat) + 1 == k && res[k]) wb_hit = 1'b1;
  end

  assign stall_raw = id_valid & ((id_src1_en & (cnt[id_src1] != '0)) |
                                 (id_src2_en & (cnt[id_src2] != '0)));
  assign stall_waw = id_valid & id_dst_we & (cnt[id_dst] > lat);
  assign stall_wb  = id_valid & id_dst_we & wb_hit;
  assign stall_div = id_valid & (id_unit == 2'd3) & (div_cnt != '0);
  assign stall     = stall_raw | stall_waw | stall_wb | stall_div;
  assign issue_go  = id_valid & ~stall;
  assign wr        = issue_go & id_dst_we;

  always_comb begin
    res_n = res >> 1;
    if (wr && lat != '0) res_n[lat] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res <= '0;
    else        res <= res_n;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n)                           cnt[r] <= '0;
      else if (wr && id_dst == RW'(r))      cnt[r] <= lat;
      else if (cnt[r] != '0)                cnt[r] <= cnt[r] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              div_cnt <= '0;
    else if (issue_go && id_unit == 2'd3)    div_cnt <= CW'(LAT_DIV - 1);
    else if (div_cnt != '0)                  div_cnt <= div_cnt - 1'b1;
  end

  // R6
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_go && id_unit == 2'd3) |=> !(issue_go && id_unit == 2'd3));

  // R3
  raw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_raw |-> (id_valid && (id_src1_en || id_src2_en)));

  // R3
  int_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue_go && id_dst_we && id_unit == 2'd0) &&
     id_valid && id_src1_en && !id_src2_en && id_src1 == $past(id_dst))
    |-> !stall_raw);

  // R7
  waw_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_waw |-> id_dst_we);

  // R4
  wb_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_wb |-> id_dst_we);

  // R8
  add_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(issue_go && id_unit == 2'd1) && id_valid &&
     id_unit == 2'd1 && !id_src1_en && !id_src2_en && id_dst != $past(id_dst))
    |-> issue_go);

endmodule

// File: tb/fp_issue_interlock_bench.sv
module fp_issue_interlock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 1'b0;
  logic [1:0] id_unit = 2'd0;
  logic [4:0] id_dst = '0, id_src1 = '0, id_src2 = '0;
  logic id_dst_we = 1'b0, id_src1_en = 1'b0, id_src2_en = 1'b0;
  logic issue_go, stall, stall_div, stall_wb, stall_raw, stall_waw;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_issue_interlock u_fp_issue_interlock (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
    .id_dst(id_dst), .id_dst_we(id_dst_we), .id_src1(id_src1),
    .id_src1_en(id_src1_en), .id_src2(id_src2), .id_src2_en(id_src2_en),
    .issue_go(issue_go), .stall(stall), .stall_div(stall_div),
    .stall_wb(stall_wb), .stall_raw(stall_raw), .stall_waw(stall_waw));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] u, input logic [4:0] d,
                       input logic we, input logic [4:0] s1, input logic e1,
                       input logic [4:0] s2, input logic e2);
    @(negedge clk);
    id_valid = v; id_unit = u; id_dst = d; id_dst_we = we;
    id_src1 = s1; id_src1_en = e1; id_src2 = s2; id_src2_en = e2;
    #1;
  endtask

  task automatic hold();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
  endtask

  task automatic stalls_until_issue(output int n);
    n = 0;
    while (!issue_go && n < 60) begin
      n++;
      hold();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    chk("R1 stall in reset", stall, 0);
    chk("R2 issue in reset", issue_go, 0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 2'd3, 5'd1, 1'b1, 5'd1, 1'b1, 5'd2, 1'b1);
    chk("R1 first div issues", issue_go, 1);
    idle(30);
  endtask

  task automatic t_valid_gate();
    drive(1'b1, 2'd1, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b0, 2'd1, 5'd8, 1'b1, 5'd8, 1'b1, 5'd0, 1'b0);
    chk("R2 stall masked", stall, 0);
    chk("R2 raw flag masked", stall_raw, 0);
    chk("R2 no issue", issue_go, 0);
    idle(30);
  endtask

  task automatic t_raw();
    int n;
    drive(1'b1, 2'd0, 5'd2, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd0, 5'd3, 1'b1, 5'd2, 1'b1, 5'd0, 1'b0);
    chk("R3 int forward issue", issue_go, 1);
    idle(30);
    drive(1'b1, 2'd1, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd1, 5'd5, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0);
    chk("R3 add dep raw flag", stall_raw, 1);
    stalls_until_issue(n);
    chk("R3 add dep stall cycles", n, 3);
    idle(30);
    drive(1'b1, 2'd2, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd0, 5'd7, 1'b1, 5'd0, 1'b0, 5'd6, 1'b1);
    stalls_until_issue(n);
    chk("R3 mul src2 stall cycles", n, 6);
    idle(30);
  endtask

  task automatic t_wb();
    drive(1'b1, 2'd1, 5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    idle(2);
    drive(1'b1, 2'd0, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R4 wb conflict", stall_wb, 1);
    chk("R9 raw clear", stall_raw, 0);
    chk("R9 waw clear", stall_waw, 0);
    chk("R9 div clear", stall_div, 0);
    hold();
    chk("R4 issue next cycle", issue_go, 1);
    idle(30);
  endtask

  task automatic t_nowrite();
    drive(1'b1, 2'd1, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    idle(2);
    drive(1'b1, 2'd0, 5'd11, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R5 nowrite issues", issue_go, 1);
    idle(30);
    drive(1'b1, 2'd1, 5'd12, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd0, 5'd13, 1'b1, 5'd12, 1'b1, 5'd0, 1'b0);
    chk("R5 no pending left", issue_go, 1);
    idle(1);
    drive(1'b1, 2'd0, 5'd14, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R5 no slot reserved", issue_go, 1);
    idle(30);
  endtask

  task automatic t_div();
    int n;
    drive(1'b1, 2'd3, 5'd14, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd0, 5'd15, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R6 int during divide", issue_go, 1);
    drive(1'b1, 2'd3, 5'd16, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R6 div busy flag", stall_div, 1);
    stalls_until_issue(n);
    chk("R6 div stall cycles", n, 22);
    idle(30);
  endtask

  task automatic t_waw();
    int n;
    drive(1'b1, 2'd2, 5'd17, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    drive(1'b1, 2'd1, 5'd17, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R7 waw flag", stall_waw, 1);
    chk("R9 no wb flag", stall_wb, 0);
    chk("R9 no raw flag", stall_raw, 0);
    stalls_until_issue(n);
    chk("R7 waw stall cycles", n, 3);
    idle(30);
  endtask

  task automatic t_pipe();
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 2'd1, 5'(18 + i), 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      chk("R8 add back to back", issue_go, 1);
    end
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, 2'd2, 5'(22 + i), 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
      chk("R8 mul back to back", issue_go, 1);
    end
    idle(30);
  endtask

  initial begin
    #(20 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_valid_gate();
    t_raw();
    t_wb();
    t_nowrite();
    t_div();
    t_waw();
    t_pipe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule